// File: doc/BRIEF.md
# Pipelined Dot-Array Refresh Sequencer

This block loads a new picture into a 12-by-12 grid of write-only storage cells and then energises every actuator attached to those cells at once. A single start strobe captures a 144-bit frame image. The sequencer then asserts the word lines one at a time, from row 0 to row 11, and places that row's slice of the captured image on the bit lines. All time is measured in ticks of a 1 ms enable input, so the block runs from a fast system clock.

Row writes can overlap. In pipelined mode each row is held only for a short step, because a cell only needs to reach partial settling before the next row starts. Only the final row waits out the full settling time. In plain mode every row gets the full settling time. Once the last row has settled, a global drive phase starts. It opens with a timed overdrive interval to speed up both rising and falling dots. It then falls back to the safe hold level and stays there until the next frame is started. The block produces only level-select signals. The analog levels are generated elsewhere.

Top module: `dot_refresh_seq`

## Requirements
- R1: At most one word line is high at any time. Rows are visited in order 0, 1, ..., 11, and row r is driven on bit r of `wordLine`.
- R2: While row r is active, `bitLine` equals bits [r*12+11 : r*12] of the frame captured at the accepted start. With no row active, `bitLine` is zero. Later changes on `frameImg` have no effect on the frame being written.
- R3: In pipelined mode (`pipeMode`=1 at start), rows 0 to 10 are each held for 10 ticks and row 11 for 40 ticks, which gives 150 ticks per frame.
- R4: In plain mode (`pipeMode`=0 at start), every row is held for 40 ticks, which gives 480 ticks per frame. The mode is sampled only when a start is accepted.
- R5: `driveEn` is low while any word line is high. It goes high only in the cycle after the last row's settling ends.
- R6: The drive phase begins with `overdriveSel` high for exactly 2500 ticks. `overdriveSel` is never high without `driveEn`.
- R7: After the overdrive interval, `driveEn` stays high and `overdriveSel` stays low until a new frame is started.
- R8: `donePulse` is high for exactly one cycle, in the first hold cycle after the overdrive interval.
- R9: A start strobe that arrives while `busy` is high (during writing or overdrive) is ignored. Row order, dwell times, frame data and overdrive length are unaffected.
- R10: A start accepted in idle or hold makes row 0 active on the next cycle, with `driveEn` low.
- R11: After reset, no word line is high, `bitLine` is zero, and `driveEn`, `overdriveSel`, `busy` and `donePulse` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle enable per 1 ms time unit |
| startPulse | input | 1 | Request to capture and write a new frame |
| pipeMode | input | 1 | 1 = pipelined row stepping, 0 = full settling per row |
| frameImg | input | 144 | Frame image; row r occupies bits r*12 upward |
| wordLine | output | 12 | One-hot row select |
| bitLine | output | 12 | Column data for the active row |
| driveEn | output | 1 | Global actuator drive enable |
| overdriveSel | output | 1 | Selects the overdrive level during drive |
| busy | output | 1 | High while writing or during overdrive |
| donePulse | output | 1 | One-cycle marker on entry to hold |

## Verification
The bench builds the block with its default parameters: 12 rows, 12 columns, and intervals of 10, 40 and 2500 ticks. The 150-tick and 480-tick frame totals and the full 2500-tick overdrive are therefore measured exactly as specified. It strobes `tickEn` once every four clocks, so every tick-counting boundary sits several clock cycles away from the others. With this spacing, an early or late row advance, or a start strobe that slips through while busy, changes a measured dwell count or the row order.

// File: rtl/dotseq_pkg.sv
package dotseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_OVERDRIVE,
    ST_HOLD
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadFrame;
    logic rowValid;
  } dpStrobe_t;

endpackage

// File: rtl/dotseq_ctrl.sv
module dotseq_ctrl
  import dotseq_pkg::*;
#(
  parameter int ROWS            = 12,
  parameter int ROW_W           = 4,
  parameter int STEP_TICKS      = 10,
  parameter int SETTLE_TICKS    = 40,
  parameter int OVERDRIVE_TICKS = 2500
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             startPulse,
  input  logic             pipeMode,
  output dpStrobe_t        strobe,
  output logic [ROW_W-1:0] rowSel,
  output logic             driveEn,
  output logic             overdriveSel,
  output logic             busy,
  output logic             donePulse
);

  localparam int MAX_WR = (STEP_TICKS > SETTLE_TICKS) ? STEP_TICKS : SETTLE_TICKS;
  localparam int MAX_T  = (MAX_WR > OVERDRIVE_TICKS) ? MAX_WR : OVERDRIVE_TICKS;
  localparam int TW     = $clog2(MAX_T + 1);

  seqState_t        state;
  logic [ROW_W-1:0] rowIdx;
  logic [TW-1:0]    tickCnt;
  logic [TW-1:0]    dwellLim;
  logic             pipeLatch;
  logic             lastRow;
  logic             startOk;
  logic             dwellEnd;
  logic             odEnd;

  assign lastRow  = (rowIdx == ROW_W'(ROWS - 1));
  assign dwellLim = (pipeLatch && !lastRow) ? TW'(STEP_TICKS) : TW'(SETTLE_TICKS);
  assign startOk  = startPulse && (state == ST_IDLE || state == ST_HOLD);
  assign dwellEnd = tickEn && (tickCnt == dwellLim - TW'(1));
  assign odEnd    = tickEn && (tickCnt == TW'(OVERDRIVE_TICKS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      rowIdx    <= '0;
      tickCnt   <= '0;
      pipeLatch <= 1'b0;
      donePulse <= 1'b0;
    end else begin
      donePulse <= 1'b0;
      case (state)
        ST_IDLE, ST_HOLD: begin
          if (startOk) begin
            state     <= ST_WRITE;
            rowIdx    <= '0;
            tickCnt   <= '0;
            pipeLatch <= pipeMode;
          end
        end
        ST_WRITE: begin
          if (dwellEnd) begin
            tickCnt <= '0;
            if (lastRow) state <= ST_OVERDRIVE;
            else         rowIdx <= rowIdx + ROW_W'(1);
          end else if (tickEn) begin
            tickCnt <= tickCnt + TW'(1);
          end
        end
        ST_OVERDRIVE: begin
          if (odEnd) begin
            state     <= ST_HOLD;
            tickCnt   <= '0;
            donePulse <= 1'b1;
          end else if (tickEn) begin
            tickCnt <= tickCnt + TW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign strobe.loadFrame = startOk;
  assign strobe.rowValid  = (state == ST_WRITE);
  assign rowSel           = rowIdx;
  assign driveEn          = (state == ST_OVERDRIVE) || (state == ST_HOLD);
  assign overdriveSel     = (state == ST_OVERDRIVE);
  assign busy             = (state == ST_WRITE) || (state == ST_OVERDRIVE);

endmodule

// File: rtl/dotseq_datapath.sv
module dotseq_datapath
  import dotseq_pkg::*;
#(
  parameter int ROWS  = 12,
  parameter int COLS  = 12,
  parameter int ROW_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic [ROW_W-1:0]     rowSel,
  input  logic [ROWS*COLS-1:0] frameImg,
  output logic [ROWS-1:0]      wordLine,
  output logic [COLS-1:0]      bitLine
);

  logic [ROWS*COLS-1:0] frameReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 frameReg <= '0;
    else if (strobe.loadFrame) frameReg <= frameImg;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_wl
    assign wordLine[r] = strobe.rowValid && (rowSel == ROW_W'(r));
  end

  always_comb begin
    bitLine = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (strobe.rowValid && rowSel == ROW_W'(r)) bitLine = frameReg[r*COLS +: COLS];
    end
  end

endmodule

// File: rtl/dot_refresh_seq.sv
module dot_refresh_seq
  import dotseq_pkg::*;
#(
  parameter int ROWS            = 12,
  parameter int COLS            = 12,
  parameter int STEP_TICKS      = 10,
  parameter int SETTLE_TICKS    = 40,
  parameter int OVERDRIVE_TICKS = 2500
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic                 startPulse,
  input  logic                 pipeMode,
  input  logic [ROWS*COLS-1:0] frameImg,
  output logic [ROWS-1:0]      wordLine,
  output logic [COLS-1:0]      bitLine,
  output logic                 driveEn,
  output logic                 overdriveSel,
  output logic                 busy,
  output logic                 donePulse
);

  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;

  dpStrobe_t        strobe;
  logic [ROW_W-1:0] rowSel;

  dotseq_ctrl #(
    .ROWS(ROWS), .ROW_W(ROW_W), .STEP_TICKS(STEP_TICKS),
    .SETTLE_TICKS(SETTLE_TICKS), .OVERDRIVE_TICKS(OVERDRIVE_TICKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .startPulse(startPulse),
    .pipeMode(pipeMode), .strobe(strobe), .rowSel(rowSel),
    .driveEn(driveEn), .overdriveSel(overdriveSel), .busy(busy),
    .donePulse(donePulse)
  );

  dotseq_datapath #(
    .ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rowSel(rowSel),
    .frameImg(frameImg), .wordLine(wordLine), .bitLine(bitLine)
  );

endmodule

// File: rtl/dotseq_checker.sv
module dotseq_checker #(
  parameter int ROWS = 12,
  parameter int COLS = 12
) (
  input logic            clk,
  input logic            rstN,
  input logic            tickEn,
  input logic            startPulse,
  input logic [ROWS-1:0] wordLine,
  input logic [COLS-1:0] bitLine,
  input logic            driveEn,
  input logic            overdriveSel,
  input logic            busy,
  input logic            donePulse
);

  a_r1_onehot_wordline: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wordLine));

  a_r2_bitline_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (wordLine == '0) |-> (bitLine == '0));

  a_r5_no_drive_while_writing: assert property (@(posedge clk) disable iff (!rstN)
    (wordLine != '0) |-> !driveEn);

  a_r6_overdrive_needs_drive: assert property (@(posedge clk) disable iff (!rstN)
    overdriveSel |-> (driveEn && busy));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  a_r8_done_in_hold: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (driveEn && !overdriveSel && !busy));

  a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startPulse && !tickEn) |=> ($stable(wordLine) && $stable(overdriveSel)));

endmodule

bind dot_refresh_seq dotseq_checker #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .startPulse(startPulse),
  .wordLine(wordLine), .bitLine(bitLine), .driveEn(driveEn),
  .overdriveSel(overdriveSel), .busy(busy), .donePulse(donePulse)
);

// File: tb/dot_refresh_seq_test.sv
module dot_refresh_seq_test;

  localparam int ROWS = 12;
  localparam int COLS = 12;
  localparam int STEP = 10;
  localparam int SETTLE = 40;
  localparam int OD = 2500;
  localparam int NB = ROWS * COLS;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tickEn = 1'b0;
  logic          startPulse = 1'b0;
  logic          pipeMode = 1'b0;
  logic [NB-1:0] frameImg = '0;
  logic [ROWS-1:0] wordLine;
  logic [COLS-1:0] bitLine;
  logic          driveEn, overdriveSel, busy, donePulse;

  int nChecks = 0;
  int nFails = 0;
  int tickPh = 0;
  bit finished = 0;

  int dwell [ROWS];
  int odTicks, totalTicks, onehotErr, dataErr, orderErr, driveErr, busyErr;
  bit doneOk, doneSeen;

  localparam logic [NB-1:0] PAT_A = {3{48'hA5C3_0F96_1E2D}};
  localparam logic [NB-1:0] PAT_B = {9{16'h9C35}};
  localparam logic [NB-1:0] PAT_C = {12{12'h6B1}};

  always #10 clk = ~clk;

  dot_refresh_seq uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .startPulse(startPulse),
    .pipeMode(pipeMode), .frameImg(frameImg), .wordLine(wordLine),
    .bitLine(bitLine), .driveEn(driveEn), .overdriveSel(overdriveSel),
    .busy(busy), .donePulse(donePulse)
  );

  initial begin
    forever begin
      @(posedge clk);
      #1;
      tickEn = (tickPh == 3);
      tickPh = (tickPh + 1) % 4;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issueStart(input logic [NB-1:0] f, input logic pm);
    @(negedge clk);
    frameImg = f;
    pipeMode = pm;
    startPulse = 1'b1;
    @(negedge clk);
  endtask

  // observes one frame from the cycle after the accepted start until donePulse
  task automatic watchFrame(input logic [NB-1:0] expF, input int injectRow,
                            input int injectOd, input logic [NB-1:0] altF);
    int curRow = -1;
    int cyc = 0;
    bit injW = 0;
    bit injO = 0;
    bit prevOd = 0;
    foreach (dwell[i]) dwell[i] = 0;
    odTicks = 0; totalTicks = 0; onehotErr = 0; dataErr = 0;
    orderErr = 0; driveErr = 0; busyErr = 0; doneOk = 0; doneSeen = 0;
    while (cyc < 20000) begin
      startPulse = 1'b0;
      if ($countones(wordLine) > 1) onehotErr++;
      if ($countones(wordLine) == 1) begin
        int r;
        r = $clog2(wordLine);
        if (r != curRow) begin
          if (r != curRow + 1) orderErr++;
          curRow = r;
        end
        if (bitLine !== expF[r*COLS +: COLS]) dataErr++;
        if (tickEn) begin dwell[r]++; totalTicks++; end
        if (driveEn) driveErr++;
        if (!busy) busyErr++;
        if (r == injectRow && !injW) begin
          injW = 1; frameImg = altF; startPulse = 1'b1;
        end
      end else if (bitLine != '0) begin
        dataErr++;
      end
      if (overdriveSel) begin
        if (!driveEn) driveErr++;
        if (!busy) busyErr++;
        if (tickEn) odTicks++;
        if (injectOd >= 0 && odTicks == injectOd && !injO) begin
          injO = 1; frameImg = altF; startPulse = 1'b1;
        end
      end
      if (donePulse) begin
        doneSeen = 1;
        doneOk = driveEn && !overdriveSel && prevOd && (curRow == ROWS - 1);
        break;
      end
      prevOd = overdriveSel;
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic testReset();
    check(wordLine == '0 && bitLine == '0, "R11 lines idle", {wordLine, bitLine}, 0);
    check(!driveEn && !overdriveSel && !busy && !donePulse, "R11 flags low",
          {driveEn, overdriveSel, busy, donePulse}, 0);
  endtask

  task automatic testPipelined();
    int badDwell = 0;
    issueStart(PAT_A, 1'b1);
    check(wordLine == 12'h001 && !driveEn, "R10 row0 after start", wordLine, 1);
    watchFrame(PAT_A, -1, -1, '0);
    for (int r = 0; r < ROWS - 1; r++) if (dwell[r] != STEP) badDwell++;
    check(badDwell == 0, "R3 short step rows", badDwell, 0);
    check(dwell[ROWS-1] == SETTLE, "R3 last row settle", dwell[ROWS-1], SETTLE);
    check(totalTicks == 150, "R3 frame total", totalTicks, 150);
    check(onehotErr == 0 && orderErr == 0, "R1 one-hot in order", onehotErr + orderErr, 0);
    check(dataErr == 0, "R2 row data", dataErr, 0);
    check(driveErr == 0, "R5 no drive while writing", driveErr, 0);
    check(odTicks == OD, "R6 overdrive length", odTicks, OD);
    check(doneSeen && doneOk, "R8 done at hold entry", doneOk, 1);
    @(negedge clk);
    check(!donePulse, "R8 done one cycle", donePulse, 0);
  endtask

  task automatic testPlain();
    int badDwell = 0;
    issueStart(PAT_B, 1'b0);
    watchFrame(PAT_B, -1, -1, '0);
    for (int r = 0; r < ROWS; r++) if (dwell[r] != SETTLE) badDwell++;
    check(badDwell == 0, "R4 full settle each row", badDwell, 0);
    check(totalTicks == 480, "R4 frame total", totalTicks, 480);
    check(dataErr == 0, "R2 row data plain", dataErr, 0);
  endtask

  task automatic testBusyStart();
    issueStart(PAT_C, 1'b1);
    watchFrame(PAT_C, 5, 1000, PAT_B);
    check(dataErr == 0, "R9 frame kept", dataErr, 0);
    check(orderErr == 0 && totalTicks == 150, "R9 no restart", totalTicks, 150);
    check(odTicks == OD, "R9 overdrive unchanged", odTicks, OD);
    check(busyErr == 0, "R9 busy during write and overdrive", busyErr, 0);
  endtask

  task automatic testHoldRestart();
    int badDwell = 0;
    bit holdBad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!driveEn || overdriveSel || busy) holdBad = 1;
    end
    check(!holdBad, "R7 hold level kept", holdBad, 0);
    issueStart(PAT_A, 1'b1);
    check(wordLine == 12'h001 && !driveEn && !overdriveSel, "R10 restart from hold",
          {driveEn, wordLine}, 1);
    pipeMode = 1'b0;
    watchFrame(PAT_A, -1, -1, '0);
    for (int r = 0; r < ROWS - 1; r++) if (dwell[r] != STEP) badDwell++;
    check(badDwell == 0 && totalTicks == 150, "R4 mode sampled at start", totalTicks, 150);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testPipelined();
    testPlain();
    testBusyStart();
    testHoldRestart();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule